// File: doc/BRIEF.md
# Parallel Flash Bank Query and Identifier Read Responder

This block supplies read data for a bank of identical flash devices wired side by side when the bank is in identifier-read mode or in table-query mode. A read presents a byte address, an access size and the mode. The block turns the byte address into a device-side table index by removing the address bits that the bank lanes consume. It then looks up either a small parameterised query table or the two identifier codes, and copies that per-device answer into every device lane of the bank word.

The bank geometry is fixed at elaboration: the bank width, the width at which each device is used, and the widest mode each device supports, all in bytes. An access wider than one bank word is built from several bank words at consecutive bank addresses. The answer is registered. It appears on the output one clock after the read strobe and stays there until the next read.

Top module: `cfiq_responder`

## Requirements
- R1: `valid_o` is high exactly in the cycle after a cycle with `rd_i` high. `rdata_o` takes the new answer at that edge and keeps its value while no read is issued. Reset drives both to zero.
- R2: The table index of a bank word is its byte address shifted right by log2(BANK_W) + log2(MAX_DEV_W) - log2(DEV_W).
- R3: In query mode (`mode_i` = 1), an index greater than or equal to TABLE_LEN gives a zero device answer.
- R4: The query table holds 0x51, 0x52, 0x59 at indices 0x10, 0x11, 0x12, 0x01 at 0x13, SIZE_LOG2 at 0x27, the buffer exponent at 0x2A, and 0x01 at 0x2C. Every other index below TABLE_LEN holds zero. The buffer exponent is 8 when BANK_W is 1 and 11 otherwise, and `wbuf_size_o` equals 2 raised to it.
- R5: When DEV_W is below MAX_DEV_W, a query answer is defined only for DEV_W = 1, where the table byte fills every byte of the device answer. Any other such geometry answers zero in query mode.
- R6: The device answer is DEV_W bytes wide: the table byte zero-extended in query mode, or the low DEV_W bytes of the zero-extended identifier code in identifier mode. It is copied into each DEV_W-byte lane of the bank word.
- R7: In identifier mode (`mode_i` = 0), only the low 8 bits of the index are decoded. 0 gives MFR_ID, 1 gives DEV_ID, and every other value gives zero.
- R8: Bank word k of an access (k = 0, 1, ...) is answered for byte address `addr_i` + k*BANK_W and placed at byte k*BANK_W of `rdata_o`, least significant byte first.
- R9: `size_i` encodes the access size as 0 = 1 byte, 1 = 2 bytes, and 2 or 3 = 4 bytes. Bytes of `rdata_o` at or above the access size read as zero.
- R10: BANK_W, DEV_W and MAX_DEV_W are each 1, 2 or 4, with DEV_W not above MAX_DEV_W or BANK_W. Any other setting is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Read strobe, one cycle per access |
| mode_i | input | 1 | 0 = identifier read, 1 = table query |
| addr_i | input | AW | Byte address of the access |
| size_i | input | 2 | Access size code |
| valid_o | output | 1 | Answer valid, one cycle after the strobe |
| rdata_o | output | 32 | Assembled and masked answer |
| wbuf_size_o | output | 16 | Write-buffer size in bytes derived from the table |

## Verification
The properties assume that `rd_i`, `mode_i`, `addr_i` and `size_i` are known whenever a strobe is sampled, and that they are only meaningful in the strobe cycle. The beyond-table property and the identifier property also assume a single-byte access, so that no later bank word wraps back into the table. The stimulus drives every input away from the clock edge and holds it over one strobe. It draws addresses from a window several times larger than the table, so both in-range and out-of-range indices occur at every geometry. Four instances with different geometries see the same stimulus, which covers the lane copy, x8 operation of a wider part, the unsupported narrow geometry and multi-word assembly.

// File: rtl/cfiq_pkg.sv
package cfiq_pkg;
  localparam logic MODE_ID    = 1'b0;
  localparam logic MODE_TABLE = 1'b1;

  function automatic int unsigned lg2w(input int unsigned v);
    return (v >= 4) ? 2 : (v >= 2) ? 1 : 0;
  endfunction

  function automatic int unsigned idx_shift(input int unsigned bw, input int unsigned dw,
                                            input int unsigned mdw);
    return lg2w(bw) + lg2w(mdw) - lg2w(dw);
  endfunction

  function automatic int unsigned buf_exp(input int unsigned bw);
    return (bw == 1) ? 8 : 11;
  endfunction

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 3'd1 : (sz == 2'd1) ? 3'd2 : 3'd4;
  endfunction
endpackage

// File: rtl/cfiq_rom.sv
module cfiq_rom #(
  parameter int unsigned IDX_W     = 16,
  parameter int unsigned TABLE_LEN = 64,
  parameter int unsigned BANK_W    = 4,
  parameter int unsigned SIZE_LOG2 = 23
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       byte_o
);
  localparam logic [7:0] BUF_EXP = 8'(cfiq_pkg::buf_exp(BANK_W));
  localparam logic [7:0] SZ_EXP  = 8'(SIZE_LOG2);

  always_comb begin
    byte_o = 8'h00;
    if (idx_i < IDX_W'(TABLE_LEN)) begin
      case (idx_i)
        IDX_W'(8'h10): byte_o = 8'h51;
        IDX_W'(8'h11): byte_o = 8'h52;
        IDX_W'(8'h12): byte_o = 8'h59;
        IDX_W'(8'h13): byte_o = 8'h01;
        IDX_W'(8'h27): byte_o = SZ_EXP;
        IDX_W'(8'h2A): byte_o = BUF_EXP;
        IDX_W'(8'h2C): byte_o = 8'h01;
        default:       byte_o = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/cfiq_lane.sv
module cfiq_lane #(
  parameter int unsigned AW        = 16,
  parameter int unsigned BANK_W    = 4,
  parameter int unsigned DEV_W     = 2,
  parameter int unsigned MAX_DEV_W = 2,
  parameter int unsigned TABLE_LEN = 64,
  parameter int unsigned SIZE_LOG2 = 23,
  parameter logic [15:0] MFR_ID    = 16'h00A7,
  parameter logic [15:0] DEV_ID    = 16'h1C3E
) (
  input  logic                  mode_i,
  input  logic [AW-1:0]         addr_i,
  output logic [8*BANK_W-1:0]   beat_o
);
  localparam int unsigned SHIFT  = cfiq_pkg::idx_shift(BANK_W, DEV_W, MAX_DEV_W);
  localparam int unsigned DEVB   = 8 * DEV_W;
  localparam int unsigned NLANE  = BANK_W / DEV_W;
  localparam bit          NARROW = (DEV_W != MAX_DEV_W);
  localparam bit          UNSUP  = NARROW && (DEV_W != 1);

  typedef logic [DEVB-1:0] dev_t;

  logic [AW-1:0] idx;
  dev_t          dev_tab;
  dev_t          dev_id;
  dev_t          dev;

  assign idx = addr_i >> SHIFT;

  generate
    if (UNSUP) begin : g_unsup
      assign dev_tab = '0;
    end else begin : g_tab
      logic [7:0] rom_byte;
      cfiq_rom #(
        .IDX_W    (AW),
        .TABLE_LEN(TABLE_LEN),
        .BANK_W   (BANK_W),
        .SIZE_LOG2(SIZE_LOG2)
      ) u_rom (
        .idx_i (idx),
        .byte_o(rom_byte)
      );
      // narrow use of a wide part: DEV_W is 1, so the byte is the whole answer
      assign dev_tab = dev_t'(rom_byte);
    end
  endgenerate

  always_comb begin
    case (idx[7:0])
      8'd0:    dev_id = dev_t'({16'h0000, MFR_ID});
      8'd1:    dev_id = dev_t'({16'h0000, DEV_ID});
      default: dev_id = '0;
    endcase
  end

  assign dev = (mode_i == cfiq_pkg::MODE_TABLE) ? dev_tab : dev_id;

  generate
    for (genvar j = 0; j < NLANE; j++) begin : g_copy
      assign beat_o[j*DEVB +: DEVB] = dev;
    end
  endgenerate
endmodule

// File: rtl/cfiq_pack.sv
module cfiq_pack (
  input  logic [31:0] words_i,
  input  logic [1:0]  size_i,
  output logic [31:0] word_o
);
  logic [2:0] nbytes;

  assign nbytes = cfiq_pkg::size_bytes(size_i);

  generate
    for (genvar b = 0; b < 4; b++) begin : g_mask
      assign word_o[8*b +: 8] = (3'(b) < nbytes) ? words_i[8*b +: 8] : 8'h00;
    end
  endgenerate
endmodule

// File: rtl/cfiq_responder.sv
module cfiq_responder #(
  parameter int unsigned AW        = 16,
  parameter int unsigned BANK_W    = 4,
  parameter int unsigned DEV_W     = 2,
  parameter int unsigned MAX_DEV_W = 2,
  parameter int unsigned TABLE_LEN = 64,
  parameter int unsigned SIZE_LOG2 = 23,
  parameter logic [15:0] MFR_ID    = 16'h00A7,
  parameter logic [15:0] DEV_ID    = 16'h1C3E
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic          mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  output logic          valid_o,
  output logic [31:0]   rdata_o,
  output logic [15:0]   wbuf_size_o
);
  localparam int unsigned NBEAT = 4 / BANK_W;
  localparam int unsigned BEATB = 8 * BANK_W;

  logic [31:0] words;
  logic [31:0] masked;
  logic [31:0] rdata_q;
  logic        valid_q;

  generate
    for (genvar k = 0; k < NBEAT; k++) begin : g_beat
      logic [AW-1:0] beat_addr;
      assign beat_addr = addr_i + AW'(k * BANK_W);
      cfiq_lane #(
        .AW       (AW),
        .BANK_W   (BANK_W),
        .DEV_W    (DEV_W),
        .MAX_DEV_W(MAX_DEV_W),
        .TABLE_LEN(TABLE_LEN),
        .SIZE_LOG2(SIZE_LOG2),
        .MFR_ID   (MFR_ID),
        .DEV_ID   (DEV_ID)
      ) u_lane (
        .mode_i(mode_i),
        .addr_i(beat_addr),
        .beat_o(words[k*BEATB +: BEATB])
      );
    end
  endgenerate

  cfiq_pack u_pack (
    .words_i(words),
    .size_i (size_i),
    .word_o (masked)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      valid_q <= rd_i;
      if (rd_i) rdata_q <= masked;
    end
  end

  assign valid_o     = valid_q;
  assign rdata_o     = rdata_q;
  assign wbuf_size_o = 16'(1) << cfiq_pkg::buf_exp(BANK_W);
endmodule

// File: rtl/cfiq_checker.sv
module cfiq_checker #(
  parameter int unsigned AW        = 16,
  parameter int unsigned BANK_W    = 4,
  parameter int unsigned DEV_W     = 2,
  parameter int unsigned MAX_DEV_W = 2,
  parameter int unsigned TABLE_LEN = 64
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_i,
  input logic          mode_i,
  input logic [AW-1:0] addr_i,
  input logic [1:0]    size_i,
  input logic          valid_o,
  input logic [31:0]   rdata_o
);
  localparam int unsigned SHIFT = cfiq_pkg::idx_shift(BANK_W, DEV_W, MAX_DEV_W);
  localparam bit UNSUP = (DEV_W != MAX_DEV_W) && (DEV_W != 1);

  logic [AW-1:0] idx;
  assign idx = addr_i >> SHIFT;

  // R10: geometry legality, checked at elaboration
  generate
    if (!(BANK_W inside {1, 2, 4}) || !(DEV_W inside {1, 2, 4}) ||
        !(MAX_DEV_W inside {1, 2, 4}) || DEV_W > MAX_DEV_W || DEV_W > BANK_W) begin : g_bad_geom_R10
      $error("cfiq_responder: illegal bank or device width");
    end
  endgenerate

  assert_valid_rise_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> valid_o);
  assert_valid_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !valid_o);
  assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  assert_mask_byte_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && size_i == 2'd0 |=> rdata_o[31:8] == 24'h0);
  assert_mask_half_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && size_i == 2'd1 |=> rdata_o[31:16] == 16'h0);

  assert_beyond_table_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && mode_i == cfiq_pkg::MODE_TABLE && size_i == 2'd0 &&
    idx >= AW'(TABLE_LEN) |=> rdata_o == 32'h0);

  assert_id_other_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && mode_i == cfiq_pkg::MODE_ID && size_i == 2'd0 && idx[7:0] > 8'd1
    |=> rdata_o == 32'h0);

  generate
    if (UNSUP) begin : g_unsup_R5
      assert_unsup_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_i && mode_i == cfiq_pkg::MODE_TABLE |=> rdata_o == 32'h0);
    end
    for (genvar b = 0; b < 4; b++) begin : g_lane_R6
      if ((b % BANK_W) >= DEV_W) begin : g_cmp
        assert_lane_copy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
          rd_i && size_i[1] |=> rdata_o[8*b +: 8] == rdata_o[8*(b-DEV_W) +: 8]);
      end
    end
  endgenerate
endmodule

bind cfiq_responder cfiq_checker #(
  .AW       (AW),
  .BANK_W   (BANK_W),
  .DEV_W    (DEV_W),
  .MAX_DEV_W(MAX_DEV_W),
  .TABLE_LEN(TABLE_LEN)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .rd_i   (rd_i),
  .mode_i (mode_i),
  .addr_i (addr_i),
  .size_i (size_i),
  .valid_o(valid_o),
  .rdata_o(rdata_o)
);

// File: tb/cfiq_responder_tb.sv
module cfiq_responder_tb;
  localparam logic [15:0] MFR = 16'h00A7;
  localparam logic [15:0] DVC = 16'h1C3E;
  localparam int TLEN = 64;
  localparam int SZL  = 23;
  // geometries: {bank, device, max device}
  localparam int BW [4]  = '{4, 1, 4, 2};
  localparam int DW [4]  = '{2, 1, 1, 2};
  localparam int MDW [4] = '{2, 1, 2, 4};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd = 1'b0;
  logic        mode = 1'b0;
  logic [15:0] addr = '0;
  logic [1:0]  size = '0;
  logic        v [4];
  logic [31:0] d [4];
  logic [15:0] w [4];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cfiq_responder #(.BANK_W(4), .DEV_W(2), .MAX_DEV_W(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .mode_i(mode), .addr_i(addr), .size_i(size),
    .valid_o(v[0]), .rdata_o(d[0]), .wbuf_size_o(w[0]));
  cfiq_responder #(.BANK_W(1), .DEV_W(1), .MAX_DEV_W(1)) u_dut_narrow (
    .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .mode_i(mode), .addr_i(addr), .size_i(size),
    .valid_o(v[1]), .rdata_o(d[1]), .wbuf_size_o(w[1]));
  cfiq_responder #(.BANK_W(4), .DEV_W(1), .MAX_DEV_W(2)) u_dut_x8 (
    .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .mode_i(mode), .addr_i(addr), .size_i(size),
    .valid_o(v[2]), .rdata_o(d[2]), .wbuf_size_o(w[2]));
  cfiq_responder #(.BANK_W(2), .DEV_W(2), .MAX_DEV_W(4)) u_dut_unsup (
    .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .mode_i(mode), .addr_i(addr), .size_i(size),
    .valid_o(v[3]), .rdata_o(d[3]), .wbuf_size_o(w[3]));

  function automatic int lg(input int x);
    return (x >= 4) ? 2 : (x >= 2) ? 1 : 0;
  endfunction

  // R4 table contents
  function automatic logic [7:0] rom_ref(input int bw, input logic [15:0] ix);
    if (ix >= 16'(TLEN)) return 8'h00;
    case (ix)
      16'h10: return 8'h51;
      16'h11: return 8'h52;
      16'h12: return 8'h59;
      16'h13: return 8'h01;
      16'h27: return 8'(SZL);
      16'h2A: return (bw == 1) ? 8'd8 : 8'd11;
      16'h2C: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(input int g, input bit qm, input logic [15:0] a,
                                         input logic [1:0] sz);
    int bw, dw, mdw, sh, nb;
    logic [31:0] r;
    logic [31:0] dev;
    logic [15:0] ba;
    logic [15:0] ix;
    bw = BW[g]; dw = DW[g]; mdw = MDW[g];
    sh = lg(bw) + lg(mdw) - lg(dw);
    nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    r = '0;
    for (int k = 0; k * bw < nb; k++) begin
      ba = a + 16'(k * bw);
      ix = ba >> sh;
      if (qm) dev = (dw != mdw && dw != 1) ? 32'h0 : {24'h0, rom_ref(bw, ix)};
      else    dev = (ix[7:0] == 8'd0) ? {16'h0, MFR} : (ix[7:0] == 8'd1) ? {16'h0, DVC} : 32'h0;
      for (int j = 0; j < bw; j++) r[8*(k*bw+j) +: 8] = dev[8*(j%dw) +: 8];
    end
    for (int b = 0; b < 4; b++) if (b >= nb) r[8*b +: 8] = 8'h00;
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one strobe, then compare every geometry one cycle later (R1)
  task automatic do_read(input string req, input bit qm, input logic [15:0] a,
                         input logic [1:0] sz);
    @(negedge clk);
    rd = 1'b1; mode = qm; addr = a; size = sz;
    @(negedge clk);
    rd = 1'b0;
    for (int g = 0; g < 4; g++) begin
      check({req, " R1 valid"}, 32'(v[g]), 32'd1);
      check(req, d[g], exp_rd(g, qm, a, sz));
    end
  endtask

  initial begin
    logic [31:0] hold [4];
    void'($urandom(32'h5EED_C0DE));
    #3;
    for (int g = 0; g < 4; g++) begin
      check("R1 reset valid", 32'(v[g]), 32'd0);
      check("R1 reset data", d[g], 32'h0);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R4 buffer size: 256 for byte-wide bank, 2048 otherwise
    check("R4 wbuf wide", 32'(w[0]), 32'd2048);
    check("R4 wbuf byte", 32'(w[1]), 32'd256);
    check("R4 wbuf x8", 32'(w[2]), 32'd2048);

    // R4/R6/R2: query signature at index 0x10 for the main bank (shift 2)
    do_read("R4 R2 query Q", 1'b1, 16'h0040, 2'd2);
    check("R6 lane copy Q", d[0], 32'h0051_0051);
    // R8: byte-wide bank assembles four words Q R Y 01
    do_read("R8 multi-word", 1'b1, 16'h0010, 2'd2);
    check("R8 assembled QRY", d[1], 32'h0159_5251);
    // R5: x8 use of x16 part, shift 3, index 0x11 on every lane
    do_read("R5 x8 fill", 1'b1, 16'h0088, 2'd2);
    check("R5 x8 R", d[2], 32'h5252_5252);
    check("R5 unsupported zero", d[3], 32'h0);
    // R4: buffer exponent entry
    do_read("R4 buf entry", 1'b1, 16'h00A8, 2'd0);
    check("R4 entry wide", d[0], 32'h0000_000B);
    do_read("R4 buf entry byte", 1'b1, 16'h002A, 2'd0);
    check("R4 entry byte", d[1], 32'h0000_0008);
    // R3: last index and first index beyond the table
    do_read("R3 last index", 1'b1, 16'(4 * (TLEN - 1)), 2'd2);
    do_read("R3 beyond table", 1'b1, 16'(4 * TLEN), 2'd2);
    check("R3 beyond zero", d[0], 32'h0);
    // R7: identifier codes, wrap of low 8 index bits, lock offsets
    do_read("R7 mfr", 1'b0, 16'h0000, 2'd2);
    check("R7 mfr lanes", d[0], 32'h00A7_00A7);
    do_read("R7 dev", 1'b0, 16'h0004, 2'd1);
    check("R7 dev half", d[0], 32'h0000_1C3E);
    do_read("R7 wrapped index", 1'b0, 16'h0404, 2'd2);
    check("R7 wrapped dev", d[0], 32'h1C3E_1C3E);
    do_read("R7 lock offset", 1'b0, 16'h0008, 2'd2);
    check("R7 lock zero", d[0], 32'h0);
    // R9: size code 3 behaves as 4 bytes, size 0 masks upper bytes
    do_read("R9 size3", 1'b1, 16'h0010, 2'd3);
    do_read("R9 size0", 1'b0, 16'h0000, 2'd0);
    check("R9 byte only", d[0], 32'h0000_00A7);

    // R1: output holds and valid stays low with no strobe
    for (int g = 0; g < 4; g++) hold[g] = d[g];
    @(negedge clk);
    mode = 1'b1; addr = 16'h0040; size = 2'd2;
    @(negedge clk);
    for (int g = 0; g < 4; g++) begin
      check("R1 idle valid", 32'(v[g]), 32'd0);
      check("R1 hold data", d[g], hold[g]);
    end

    // constrained random over both modes, all sizes, addresses past the table
    for (int i = 0; i < 400; i++) begin
      do_read("R2 R3 R6 R7 R8 R9 random", 1'($urandom_range(0, 1)),
              16'($urandom_range(0, 1023)), 2'($urandom_range(0, 3)));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule